// File: doc/BRIEF.md
# Serial SPI EEPROM Slave

This block is the target side of a byte-wide serial EEPROM with 8192 one-byte locations, reached over a four-wire SPI link. A host lowers chip select, clocks in an 8-bit command and, for the array commands, a 16-bit address. It then either streams bytes out or streams bytes into a 64-byte page buffer. Data going in is taken on rising SCK edges and data coming out changes on falling SCK edges, so a host may idle SCK either low or high.

A write is staged in the page buffer. It is committed to the array by a self-timed cycle that begins once chip select returns high, and only if the write-enable latch was set beforehand. A status byte reports the busy flag and the write-enable latch and holds two block-protect bits and a status-guard bit. A hold input freezes a transfer part way through without losing its progress. All pins are sampled by the block clock, and SCK must be several block clocks per half period.

Top module: `eeprom_spi_slave`

## Requirements
- R1: After reset the status byte reads 0x00 and the serial output enable is low.
- R2: Both SCK polarities work: SI is taken on rising SCK, SO changes on falling SCK, and SCK may idle low or high while chip select is high.
- R3: While chip select is high, the output enable is low. Raising chip select ends any transfer, and the next command starts afresh.
- R4: The accepted commands are 0x06 (set write enable), 0x04 (clear write enable), 0x05 (read status), 0x01 (write status), 0x03 (read) and 0x02 (write). Any other first byte makes the block ignore the rest of the transfer, with no output and no change of state.
- R5: The status byte has bit 0 = busy, bit 1 = write enable, bits 3:2 = protect level and bit 7 = status guard; all other bits read 0. Command 0x06 sets bit 1 and command 0x04 clears it, each taking effect when chip select rises.
- R6: A read sends a 16-bit address whose top 3 bits are ignored, then returns consecutive bytes. The address steps across the whole array and wraps from 0x1FFF to 0x0000.
- R7: Write data is buffered with the address stepping inside the 64-byte page, wrapping from offset 63 to offset 0. The buffered bytes reach the array only after chip select rises.
- R8: A write or status write does nothing unless the write-enable bit is 1 when chip select rises and the last byte is complete at that moment.
- R9: A started cycle keeps the busy bit at 1 for WR_CYC clocks and then clears the busy and write-enable bits. While busy, every command except read status is ignored.
- R10: Protect level 1 guards 0x1800 to 0x1FFF, level 2 guards 0x1000 to 0x1FFF and level 3 guards the whole array. A write whose page is guarded is discarded.
- R11: With the status guard bit at 1 and wp_n low, a status write is discarded. With wp_n high it proceeds.
- R12: Lowering hold_n while SCK is low suspends the transfer: the output enable drops and SCK and SI are ignored. Raising hold_n while SCK is low resumes the transfer at the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| wp_n | input | 1 | Status write guard pin, active low |
| hold_n | input | 1 | Transfer suspend, active low |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | High when so must be driven onto the line |

## Verification
The assertions assume that hold_n changes only while SCK is low. They also assume that SCK, SI and chip select stay stable for several block clocks around each edge, so that each SCK edge is seen exactly once. The bench drives every pin on the falling block clock and holds each SCK half period for four block clocks. It toggles hold_n only after parking SCK low, and it waits longer than WR_CYC before it expects a write cycle to have finished.

// File: rtl/eep_pkg.sv
// Shared opcodes and state encodings for the serial EEPROM slave.
// Assumes 8-bit commands with the values listed in the brief.
package eep_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        ST_CMD, ST_AHI, ST_ALO, ST_WDAT, ST_SRV, ST_OUT, ST_SKIP
    } eep_state_t;

    typedef enum logic [2:0] {
        PD_NONE, PD_WREN, PD_WRDI, PD_WRSR, PD_WRITE
    } eep_pend_t;
endpackage

// File: rtl/eep_front.sv
// Pin front end: turns the sampled SCK and chip select into single-cycle
// edge pulses and tracks the hold condition.
// Assumes SCK half periods last several clk cycles and hold_n moves only with SCK low.
module eep_front (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_end,
    output logic held
);
    logic sck_q;
    logic cs_q;
    logic live;

    // Remember the previous pin levels and update hold only while SCK is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
            held  <= 1'b0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n)
                held <= 1'b0;
            else if (!sck)
                held <= !hold_n;
        end
    end

    // Edges count only inside a selected, non-held transfer.
    always_comb begin
        live     = !cs_n && !cs_q && !held;
        sck_rise = live && sck && !sck_q;
        sck_fall = live && !sck && sck_q;
        cs_end   = cs_n && !cs_q;
    end

    assert_hold_low_sck_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> !$past(sck));
endmodule

// File: rtl/eep_guard.sv
// Protection decisions: maps the protect level onto an address range and
// decides whether a status write may go ahead.
// Assumes the address is a page base padded with zero offset bits.
module eep_guard #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        level,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp_n,
    input  logic              guard_bit,
    output logic              addr_locked,
    output logic              sr_locked
);
    // Compare the top address bits against the guarded fraction of the array.
    always_comb begin
        unique case (level)
            2'd1:    addr_locked = (addr[ADDR_W-1 -: 2] == 2'b11);
            2'd2:    addr_locked = addr[ADDR_W-1];
            2'd3:    addr_locked = 1'b1;
            default: addr_locked = 1'b0;
        endcase
        sr_locked = guard_bit && !wp_n;
    end
endmodule

// File: rtl/eep_store.sv
// Byte array plus the page staging buffer with one valid flag per byte.
// A commit copies every flagged byte into its page in one clock.
// Assumes the controller never stages bytes while a commit is pending.
module eep_store #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_clr,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_din,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] page_base,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     pending
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [7:0]      mem  [DEPTH];
    logic [7:0]      pbuf [PAGE];
    logic [PAGE-1:0] valid;

    // Track which staging slots hold data for the next commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid <= '0;
        else if (buf_clr || commit)
            valid <= '0;
        else if (buf_we)
            valid[buf_idx] <= 1'b1;
    end

    // Stage incoming bytes.
    always_ff @(posedge clk) begin
        if (buf_we)
            pbuf[buf_idx] <= buf_din;
    end

    // Copy flagged slots into the array page.
    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE; i++) begin
            if (commit && valid[i])
                mem[{page_base, i[PAGE_W-1:0]}] <= pbuf[i];
        end
    end

    assign rd_data = mem[rd_addr];
    assign pending = |valid;

    assert_commit_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> pending);
endmodule

// File: rtl/eeprom_spi_slave.sv
// Serial EEPROM slave: command decode, address handling, streamed reads,
// page-buffered writes, status register, protection and a timed write cycle.
// Assumes pins are sampled by clk with SCK half periods of several clk cycles.
module eeprom_spi_slave #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 6,
    parameter int WR_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    import eep_pkg::*;

    localparam int CNT_W = $clog2(WR_CYC + 1);
    localparam int PB_W  = ADDR_W - PAGE_W;

    logic sck_rise, sck_fall, cs_end, held;
    eep_state_t state;
    eep_pend_t  pend;
    logic [2:0]  bit_cnt, ocnt;
    logic [6:0]  sh;
    logic [7:0]  addr_hi, osr, srv, byte_in, next_out, status_now, rd_data;
    logic        is_rd, sr_mode, out_act, so_q;
    logic        wel, wpen, busy, job_sr;
    logic [1:0]  bp;
    logic [CNT_W-1:0] wr_cnt;
    logic [ADDR_W-1:0] rd_addr, a_new;
    logic [PB_W-1:0]   page_base;
    logic [PAGE_W-1:0] wptr;
    logic [15:0] a_full;
    logic        byte_done, buf_we, buf_clr, commit, pending;
    logic        page_locked, sr_locked;

    eep_front u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_end(cs_end), .held(held)
    );

    eep_guard #(.ADDR_W(ADDR_W)) u_guard (
        .level(bp), .addr({page_base, {PAGE_W{1'b0}}}), .wp_n(wp_n),
        .guard_bit(wpen), .addr_locked(page_locked), .sr_locked(sr_locked)
    );

    eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_idx(wptr), .buf_din(byte_in), .commit(commit), .page_base(page_base),
        .rd_addr(rd_addr), .rd_data(rd_data), .pending(pending)
    );

    // Decode helpers: completed byte, next outgoing byte, staging strobes.
    always_comb begin
        byte_in    = {sh, si};
        byte_done  = sck_rise && (bit_cnt == 3'd7);
        a_full     = {addr_hi, byte_in};
        a_new      = a_full[ADDR_W-1:0];
        status_now = {wpen, 3'b000, bp, wel, busy};
        next_out   = (ocnt == 3'd0) ? (sr_mode ? status_now : rd_data) : osr;
        buf_we     = byte_done && (state == ST_WDAT);
        buf_clr    = byte_done && (state == ST_ALO) && !is_rd;
        commit     = busy && (wr_cnt == '0) && !job_sr;
    end

    // Main controller: write-cycle timer, end-of-transfer actions, bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CMD;   pend <= PD_NONE;  bit_cnt <= '0;  ocnt <= '0;
            sh <= '0;          addr_hi <= '0;    osr <= '0;      srv <= '0;
            is_rd <= 1'b0;     sr_mode <= 1'b0;  out_act <= 1'b0; so_q <= 1'b0;
            wel <= 1'b0;       wpen <= 1'b0;     busy <= 1'b0;   job_sr <= 1'b0;
            bp <= '0;          wr_cnt <= '0;     rd_addr <= '0;  page_base <= '0;
            wptr <= '0;
        end else begin
            if (busy) begin
                if (wr_cnt == '0) begin
                    busy <= 1'b0;
                    wel  <= 1'b0;
                    if (job_sr) begin
                        wpen <= srv[7];
                        bp   <= srv[3:2];
                    end
                end else begin
                    wr_cnt <= wr_cnt - 1'b1;
                end
            end
            if (cs_n) begin
                state   <= ST_CMD;
                pend    <= PD_NONE;
                bit_cnt <= '0;
                out_act <= 1'b0;
            end
            if (cs_end && bit_cnt == 3'd0 && !busy) begin
                unique case (pend)
                    PD_WREN: wel <= 1'b1;
                    PD_WRDI: wel <= 1'b0;
                    PD_WRSR: if (wel && !sr_locked) begin
                        busy <= 1'b1; wr_cnt <= CNT_W'(WR_CYC - 1); job_sr <= 1'b1;
                    end
                    PD_WRITE: if (wel && pending && !page_locked) begin
                        busy <= 1'b1; wr_cnt <= CNT_W'(WR_CYC - 1); job_sr <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (sck_rise) begin
                sh      <= byte_in[6:0];
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_done) begin
                unique case (state)
                    ST_CMD: begin
                        state <= ST_SKIP;
                        if (!busy || byte_in == OP_RDSR) begin
                            unique case (byte_in)
                                OP_WREN:  pend <= PD_WREN;
                                OP_WRDI:  pend <= PD_WRDI;
                                OP_RDSR:  begin state <= ST_OUT; sr_mode <= 1'b1; ocnt <= '0; end
                                OP_WRSR:  state <= ST_SRV;
                                OP_READ:  begin state <= ST_AHI; is_rd <= 1'b1; end
                                OP_WRITE: begin state <= ST_AHI; is_rd <= 1'b0; end
                                default:  ;
                            endcase
                        end
                    end
                    ST_AHI: begin
                        addr_hi <= byte_in;
                        state   <= ST_ALO;
                    end
                    ST_ALO: begin
                        if (is_rd) begin
                            rd_addr <= a_new;
                            sr_mode <= 1'b0;
                            ocnt    <= '0;
                            state   <= ST_OUT;
                        end else begin
                            page_base <= a_new[ADDR_W-1:PAGE_W];
                            wptr      <= a_new[PAGE_W-1:0];
                            pend      <= PD_WRITE;
                            state     <= ST_WDAT;
                        end
                    end
                    ST_WDAT: wptr <= wptr + 1'b1;
                    ST_SRV: begin
                        srv   <= byte_in;
                        pend  <= PD_WRSR;
                        state <= ST_SKIP;
                    end
                    default: ;
                endcase
            end
            if (sck_fall && state == ST_OUT) begin
                so_q    <= next_out[7];
                osr     <= {next_out[6:0], 1'b0};
                ocnt    <= ocnt + 1'b1;
                out_act <= 1'b1;
                if (ocnt == 3'd0 && !sr_mode)
                    rd_addr <= rd_addr + 1'b1;
            end
        end
    end

    assign so    = so_q;
    assign so_oe = out_act && !cs_n && !held;

    assert_wel_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);
    assert_cycle_at_cs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_n));
    assert_level_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp) |-> $past(busy));
    assert_guarded_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && job_sr) |-> !(!$past(wp_n) && $past(wpen)));
endmodule

// File: tb/sim_eeprom_spi_slave.sv
module sim_eeprom_spi_slave;
    localparam int WRC = 250;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
    logic so, so_oe;
    logic mode3 = 1'b0;
    int checks = 0;
    int errors = 0;
    logic [7:0] model [8192];

    eeprom_spi_slave #(.ADDR_W(13), .PAGE_W(6), .WR_CYC(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .wp_n(wp_n), .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    always #10 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cs_go();
        sck = mode3; tick(4); cs_n = 1'b0; tick(4);
    endtask

    task automatic cs_stop();
        if (!mode3) sck = 1'b0;
        tick(4); cs_n = 1'b1; tick(4);
    endtask

    task automatic xfer(input logic [7:0] d, output logic [7:0] q);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = d[i]; tick(4);
            q[i] = so;
            sck = 1'b1; tick(4);
        end
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] q;
        cs_go(); xfer(op, q); cs_stop();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] q;
        cs_go(); xfer(8'h05, q); xfer(8'h00, st); cs_stop();
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input int n, input bit ok);
        logic [7:0] q;
        cmd(8'h06);
        cs_go(); xfer(8'h02, q); xfer(a[15:8], q); xfer(a[7:0], q);
        for (int i = 0; i < n; i++) begin
            xfer(d[31-8*i -: 8], q);
            if (ok) model[{a[12:6], 6'(a[5:0] + i)}] = d[31-8*i -: 8];
        end
        cs_stop(); tick(WRC + 20);
    endtask

    task automatic rd(input logic [15:0] a, input int n, output logic [31:0] r);
        logic [7:0] q;
        r = '0;
        cs_go(); xfer(8'h03, q); xfer(a[15:8], q); xfer(a[7:0], q);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, q);
            r[31-8*i -: 8] = q;
        end
        cs_stop();
    endtask

    function automatic logic [31:0] mread(input logic [12:0] a, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[31-8*i -: 8] = model[13'(a + i)];
        return r;
    endfunction

    task automatic t_reset();
        logic [7:0] st;
        check("R1 oe after reset", {31'd0, so_oe}, 32'd0);
        rdsr(st);
        check("R1 status after reset", {24'd0, st}, 32'h00);
        check("R3 oe with cs high", {31'd0, so_oe}, 32'd0);
    endtask

    task automatic t_wel();
        logic [7:0] st;
        cmd(8'h06); rdsr(st);
        check("R5 WEL set", {24'd0, st}, 32'h02);
        cmd(8'h04); rdsr(st);
        check("R5 WEL cleared", {24'd0, st}, 32'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] st, q;
        logic [31:0] r;
        cmd(8'h06);
        cs_go(); xfer(8'h02, q); xfer(8'h01, q); xfer(8'h00, q);
        xfer(8'hDE, q); xfer(8'hAD, q); xfer(8'hBE, q); xfer(8'hEF, q);
        cs_stop();
        model[13'h100] = 8'hDE; model[13'h101] = 8'hAD;
        model[13'h102] = 8'hBE; model[13'h103] = 8'hEF;
        rdsr(st);
        check("R9 busy and WEL during cycle", {24'd0, st}, 32'h03);
        cs_go(); xfer(8'h03, q); xfer(8'h01, q); xfer(8'h00, q); xfer(8'h00, q);
        check("R9 read ignored while busy", {31'd0, so_oe}, 32'd0);
        cs_stop();
        tick(WRC);
        rdsr(st);
        check("R9 busy and WEL clear after cycle", {24'd0, st}, 32'h00);
        rd(16'h0100, 4, r);
        check("R7 R2 mode 0 readback", r, 32'hDEADBEEF);
        mode3 = 1'b1;
        rd(16'h0100, 4, r);
        check("R2 mode 3 readback", r, 32'hDEADBEEF);
        mode3 = 1'b0;
    endtask

    task automatic t_page_wrap();
        logic [31:0] r;
        wr(16'h013E, 32'h11223344, 4, 1'b1);
        rd(16'h013E, 2, r);
        check("R7 bytes before wrap", r[31:16], 32'h1122);
        rd(16'h0100, 2, r);
        check("R7 wrap to page start", r[31:16], 32'h3344);
    endtask

    task automatic t_read_wrap();
        logic [31:0] r;
        wr(16'h1FFF, 32'hA5000000, 1, 1'b1);
        wr(16'h0000, 32'h5A000000, 1, 1'b1);
        rd(16'hFFFF, 2, r);
        check("R6 array wrap and ignored top bits", r, mread(13'h1FFF, 2));
    endtask

    task automatic t_gating();
        logic [7:0] st, q;
        logic [31:0] r;
        wr(16'h0200, 32'h77000000, 1, 1'b1);
        cs_go(); xfer(8'h02, q); xfer(8'h02, q); xfer(8'h00, q); xfer(8'h99, q); cs_stop();
        tick(WRC + 20);
        rd(16'h0200, 1, r);
        check("R8 write without WEL dropped", r[31:24], 32'h77);
        cmd(8'h06);
        cs_go(); xfer(8'h02, q); xfer(8'h02, q); xfer(8'h00, q); xfer(8'h88, q);
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; si = 1'b1; tick(4); sck = 1'b1; tick(4);
        end
        cs_stop();
        rdsr(st);
        check("R8 partial byte starts no cycle", {24'd0, st}, 32'h02);
        rd(16'h0200, 1, r);
        check("R8 partial byte write dropped", r[31:24], 32'h77);
        cmd(8'h04);
    endtask

    task automatic t_bad_op();
        logic [7:0] st, q;
        cs_go(); xfer(8'hAB, q); xfer(8'h06, q); xfer(8'h00, q);
        check("R4 unknown opcode gives no output", {31'd0, so_oe}, 32'd0);
        cs_stop();
        rdsr(st);
        check("R4 unknown opcode leaves status", {24'd0, st}, 32'h00);
        cs_go(); xfer(8'h06, q);
        cs_stop();
        cs_go(); xfer(8'h05, q); cs_stop();
        cs_go(); xfer(8'h04, q); tick(2); cs_n = 1'b1; tick(4);
        rdsr(st);
        check("R3 fresh command after cs rise", {24'd0, st}, 32'h00);
    endtask

    task automatic t_protect();
        logic [7:0] st, q;
        logic [31:0] r;
        wr(16'h1800, 32'h11000000, 1, 1'b1);
        wr(16'h1000, 32'h22000000, 1, 1'b1);
        wr(16'h0040, 32'h33000000, 1, 1'b1);
        cmd(8'h06);
        cs_go(); xfer(8'h01, q); xfer(8'h04, q); cs_stop(); tick(WRC + 20);
        rdsr(st);
        check("R10 level 1 stored", {24'd0, st}, 32'h04);
        wr(16'h1800, 32'hE1000000, 1, 1'b0);
        wr(16'h1000, 32'hE2000000, 1, 1'b1);
        rd(16'h1800, 1, r);
        check("R10 upper quarter guarded", r[31:24], {24'd0, model[13'h1800]});
        rd(16'h1000, 1, r);
        check("R10 below quarter writable", r[31:24], 32'hE2);
        cmd(8'h04);
        cmd(8'h06);
        cs_go(); xfer(8'h01, q); xfer(8'h08, q); cs_stop(); tick(WRC + 20);
        wr(16'h1000, 32'hF2000000, 1, 1'b0);
        rd(16'h1000, 1, r);
        check("R10 upper half guarded", r[31:24], 32'hE2);
        cmd(8'h04);
        cmd(8'h06);
        cs_go(); xfer(8'h01, q); xfer(8'h0C, q); cs_stop(); tick(WRC + 20);
        wr(16'h0040, 32'hF3000000, 1, 1'b0);
        rd(16'h0040, 1, r);
        check("R10 whole array guarded", r[31:24], 32'h33);
        cmd(8'h04);
        cmd(8'h06);
        cs_go(); xfer(8'h01, q); xfer(8'h00, q); cs_stop(); tick(WRC + 20);
        rdsr(st);
        check("R10 level cleared", {24'd0, st}, 32'h00);
    endtask

    task automatic t_wp();
        logic [7:0] st, q;
        cmd(8'h06);
        cs_go(); xfer(8'h01, q); xfer(8'h80, q); cs_stop(); tick(WRC + 20);
        rdsr(st);
        check("R11 guard bit set", {24'd0, st}, 32'h80);
        wp_n = 1'b0;
        cmd(8'h06);
        cs_go(); xfer(8'h01, q); xfer(8'h00, q); cs_stop(); tick(WRC + 20);
        rdsr(st);
        check("R11 status write blocked", {24'd0, st}, 32'h82);
        wp_n = 1'b1;
        cs_go(); xfer(8'h01, q); xfer(8'h00, q); cs_stop(); tick(WRC + 20);
        rdsr(st);
        check("R11 status write with pin high", {24'd0, st}, 32'h00);
    endtask

    task automatic t_hold();
        logic [7:0] q1, q2, q;
        cs_go(); xfer(8'h03, q); xfer(8'h01, q); xfer(8'h00, q); xfer(8'h00, q1);
        sck = 1'b0; tick(4);
        hold_n = 1'b0; tick(4);
        check("R12 output off in hold", {31'd0, so_oe}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            si = 1'b1; sck = 1'b1; tick(4); sck = 1'b0; tick(4);
        end
        hold_n = 1'b1; tick(4);
        check("R12 output back after hold", {31'd0, so_oe}, 32'd1);
        xfer(8'h00, q2);
        cs_stop();
        check("R12 byte before hold", {24'd0, q1}, {24'd0, model[13'h100]});
        check("R12 byte after hold", {24'd0, q2}, {24'd0, model[13'h101]});
    endtask

    initial begin
        for (int i = 0; i < 8192; i++) model[i] = 8'h00;
        tick(5); rst_n = 1'b1; tick(3);
        t_reset();
        t_wel();
        t_write_read();
        t_page_wrap();
        t_read_wrap();
        t_gating();
        t_bad_op();
        t_protect();
        t_wp();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule